// File: doc/BRIEF.md
# Aligned Transfer Segment Splitter

This block turns one transfer request (start address, byte count) into a sequence of address/length segments. Each segment fits in a single hardware buffer of at most 0x1FFF bytes. An oversized remainder is not cut into full-size pieces with a short tail. It is cut into nearly equal pieces that are multiples of four bytes, so every segment boundary stays word aligned and no tiny trailing segment appears.

A cyclic mode serves ring buffers. The request also carries a period length. Each whole period inside the buffer is split on its own, and the segment that closes a period is flagged. Requests with a misaligned start address, a zero length, or an unusable period get a one-cycle error response and produce no segments. The request side and the segment side are both valid/ready handshakes. The segment side holds its output until the consumer takes it. The divisions use a shared bit-serial divider, so the request side stays busy while a request is being split.

Top module: `seg_splitter`

## Requirements
- R1: Every emitted segment has a length between 1 and 0x1FFF bytes inclusive.
- R2: A request whose address has bit 1 or bit 0 set is accepted and rejected. `req_err` is high for exactly the one cycle after acceptance, and no segment follows.
- R3: A request is also rejected the same way when its length is zero, or, in cyclic mode, when its period is zero or larger than its length.
- R4: When the remaining length of the current piece is at most 0x1FFF, it is emitted whole as that piece's final segment.
- R5: When the remaining length L exceeds 0x1FFF, the segment length is floor(L / m) with its two low bits cleared, where m = ceil(L / 0x1FFC). Such a non-final segment is therefore a multiple of 4.
- R6: The first segment starts at the request address, and each later segment starts at the previous segment's address plus its length, across period boundaries too.
- R7: In non-cyclic mode the whole length is one piece. Its final segment carries both `seg_eop` and `seg_last`, and no earlier segment carries either.
- R8: In cyclic mode the block emits floor(length / period) periods, each split independently by R4/R5. `seg_eop` marks the final segment of every period. `seg_last` marks only the final segment of the final period, and any remainder of the length beyond the whole periods is not emitted.
- R9: `req_ready` is high only while no request is in progress. It is low from acceptance of a valid request until the handshake of its `seg_last` segment.
- R10: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len`, `seg_eop` and `seg_last` hold their values.
- R11: After reset `req_ready` is 1, and `seg_valid` and `req_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this cycle if valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Total byte count |
| req_cyclic | input | 1 | Cyclic mode select |
| req_period | input | LEN_W | Period length in bytes (cyclic mode only) |
| req_err | output | 1 | One-cycle pulse: last accepted request rejected |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| seg_eop | output | 1 | Final segment of a period (or of the whole request) |
| seg_last | output | 1 | Final segment of the request |

## Verification
The properties assume that the consumer drives `seg_ready` freely, with no protocol demands of its own. They also assume that a new request is only offered when `req_ready` is high. The contiguity property additionally assumes that the address does not wrap past the top of the address space within one request. The stimulus keeps every request well below that boundary. It stalls `seg_ready` with a pseudo-random pattern, and it offers each new request only after `req_ready` is observed high.

// File: rtl/seg_split_pkg.sv
// Shared types for the segment splitter.
package seg_split_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a request
        ST_PLAN,     // decide: emit remainder whole or start division
        ST_DIV_CNT,  // computing piece count m = ceil(L / step)
        ST_DIV_LEN,  // computing piece length L / m
        ST_EMIT      // segment presented on the output
    } seg_state_e;
endpackage

// File: rtl/seg_divider.sv
// Bit-serial restoring unsigned divider.
// Loads operands on start and raises done for one cycle W cycles later.
// The quotient stays valid until the next start. Assumes divisor != 0.
module seg_divider #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc;
    logic [W-1:0]  quo;
    logic [W-1:0]  dvs;
    logic [CW-1:0] cnt;
    logic          running;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {acc, quo[W-1]};
        diff    = shifted - {1'b0, dvs};
        fits    = shifted >= {1'b0, dvs};
    end

    // One quotient bit per cycle; done pulses when the last bit is formed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            quo     <= '0;
            dvs     <= '0;
            cnt     <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc     <= '0;
                quo     <= dividend;
                dvs     <= divisor;
                cnt     <= CW'(W);
                running <= 1'b1;
            end else if (running) begin
                acc <= fits ? diff[W-1:0] : shifted[W-1:0];
                quo <= {quo[W-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo;
endmodule

// File: rtl/seg_req_check.sv
// Combinational request screening: flags requests that must be refused.
// Assumes nothing about the request beyond its fields.
module seg_req_check #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              cyclic,
    input  logic [LEN_W-1:0]  period,
    output logic              bad
);
    // Misalignment, empty request, or an unusable period in cyclic mode.
    always_comb begin
        bad = (addr[1:0] != 2'b00) || (len == '0) ||
              (cyclic && ((period == '0) || (period > len)));
    end
endmodule

// File: rtl/seg_splitter.sv
// Splits an aligned transfer request into buffer-sized, word-aligned
// segments of near-equal length; cyclic mode splits per period.
// Assumes MAX_SEG fits in LEN_W bits and is at least 4.
module seg_splitter
    import seg_split_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          LEN_W   = 32,
    parameter logic [15:0] MAX_SEG = 16'h1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_cyclic,
    input  logic [LEN_W-1:0]  req_period,
    output logic              req_err,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_eop,
    output logic              seg_last
);
    localparam int         DIV_W = LEN_W + 1;
    localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_SEG);
    localparam logic [LEN_W-1:0] STEP = LEN_W'(MAX_SEG & 16'hFFFC);

    seg_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  per_len;
    logic [LEN_W-1:0]  size_left;
    logic [LEN_W-1:0]  len_r;
    logic              err_r;
    logic              bad;
    logic              div_start;
    logic              div_done;
    logic [DIV_W-1:0]  div_a;
    logic [DIV_W-1:0]  div_b;
    logic [DIV_W-1:0]  div_q;
    logic [LEN_W-1:0]  next_left;
    logic              more_periods;
    logic              piece_end;

    seg_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
        .addr   (req_addr),
        .len    (req_len),
        .cyclic (req_cyclic),
        .period (req_period),
        .bad    (bad)
    );

    seg_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q)
    );

    // Divider operand selection: first the piece count, then the piece length.
    always_comb begin
        div_start = ((state == ST_PLAN) && (rem > MAXL)) ||
                    ((state == ST_DIV_CNT) && div_done);
        if (state == ST_PLAN) begin
            div_a = {1'b0, rem} + DIV_W'(STEP) - DIV_W'(1);
            div_b = DIV_W'(STEP);
        end else begin
            div_a = {1'b0, rem};
            div_b = div_q;
        end
    end

    // Segment flags derived from the current piece and remaining periods.
    always_comb begin
        next_left    = size_left - per_len;
        more_periods = next_left >= per_len;
        piece_end    = (len_r == rem);
    end

    // Main sequencer: accept, plan, divide, emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            rem       <= '0;
            per_len   <= '0;
            size_left <= '0;
            len_r     <= '0;
            err_r     <= 1'b0;
        end else begin
            err_r <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (bad) begin
                            err_r <= 1'b1;
                        end else begin
                            cur_addr  <= req_addr;
                            per_len   <= req_cyclic ? req_period : req_len;
                            rem       <= req_cyclic ? req_period : req_len;
                            size_left <= req_len;
                            state     <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN: begin
                    if (rem <= MAXL) begin
                        len_r <= rem;
                        state <= ST_EMIT;
                    end else begin
                        state <= ST_DIV_CNT;
                    end
                end
                ST_DIV_CNT: begin
                    if (div_done) state <= ST_DIV_LEN;
                end
                ST_DIV_LEN: begin
                    if (div_done) begin
                        len_r <= div_q[LEN_W-1:0] & ~LEN_W'(3);
                        state <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (seg_ready) begin
                        cur_addr <= cur_addr + ADDR_W'(len_r);
                        if (!piece_end) begin
                            rem   <= rem - len_r;
                            state <= ST_PLAN;
                        end else if (more_periods) begin
                            rem       <= per_len;
                            size_left <= next_left;
                            state     <= ST_PLAN;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign req_err   = err_r;
    assign seg_valid = (state == ST_EMIT);
    assign seg_addr  = cur_addr;
    assign seg_len   = len_r;
    assign seg_eop   = seg_valid && piece_end;
    assign seg_last  = seg_valid && piece_end && !more_periods;
endmodule

// File: rtl/seg_splitter_chk.sv
// Protocol and ordering properties of the segment splitter, bound to it.
// Assumes requests are offered only while req_ready is high.
module seg_splitter_chk #(
    parameter int          ADDR_W  = 32,
    parameter int          LEN_W   = 32,
    parameter logic [15:0] MAX_SEG = 16'h1FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_err,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              seg_eop,
    input logic              seg_last
);
    logic [ADDR_W-1:0] exp_next;
    logic              have_next;

    // Track the address the following segment must start at.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_next  <= '0;
            have_next <= 1'b0;
        end else if (seg_valid && seg_ready) begin
            exp_next  <= seg_addr + ADDR_W'(seg_len);
            have_next <= !seg_last;
        end
    end

    p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0) && (seg_len <= LEN_W'(MAX_SEG)));

    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !seg_valid);

    p_err_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (req_err || !req_ready));

    p_mid_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_eop) |-> (seg_len[1:0] == 2'b00));

    p_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && have_next) |-> (seg_addr == exp_next));

    p_last_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_last) |-> seg_eop);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !req_ready);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> seg_valid && $stable(seg_addr) &&
        $stable(seg_len) && $stable(seg_eop) && $stable(seg_last));
endmodule

bind seg_splitter seg_splitter_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .MAX_SEG(MAX_SEG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_err   (req_err),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_eop   (seg_eop),
    .seg_last  (seg_last)
);

// File: tb/sim_seg_splitter.sv
module sim_seg_splitter;
    localparam int AW = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_cyclic = 1'b0;
    logic [LW-1:0] req_period = '0;
    logic          req_err;
    logic          seg_valid;
    logic          seg_ready = 1'b0;
    logic [AW-1:0] seg_addr;
    logic [LW-1:0] seg_len;
    logic          seg_eop;
    logic          seg_last;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    bit stall_mode = 1'b0;

    longint e_addr [0:127];
    longint e_len  [0:127];
    bit     e_eop  [0:127];
    bit     e_last [0:127];
    bit     e_big  [0:127];
    int     e_n;

    always #4 clk = ~clk;

    seg_splitter #(.ADDR_W(AW), .LEN_W(LW), .MAX_SEG(16'h1FFF)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_cyclic(req_cyclic),
        .req_period(req_period), .req_err(req_err), .seg_valid(seg_valid),
        .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
        .seg_eop(seg_eop), .seg_last(seg_last)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference split of a request, computed arithmetically.
    task automatic build_exp(input longint addr, input longint len,
                             input bit cyc, input longint per);
        longint a = addr;
        longint nper = cyc ? len / per : 1;
        longint plen = cyc ? per : len;
        e_n = 0;
        for (longint p = 0; p < nper; p++) begin
            longint r = plen;
            while (r > 0) begin
                longint s;
                longint m;
                if (r <= 8191) begin
                    s = r;
                    e_big[e_n] = 1'b0;
                end else begin
                    m = (r + 8187) / 8188;
                    s = (r / m) & ~longint'(3);
                    e_big[e_n] = 1'b1;
                end
                e_addr[e_n] = a;
                e_len[e_n]  = s;
                e_eop[e_n]  = (s == r);
                e_last[e_n] = (s == r) && (p == nper - 1);
                a = a + s;
                r = r - s;
                e_n++;
            end
        end
    endtask

    task automatic offer(input longint addr, input longint len,
                         input bit cyc, input longint per);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_addr   = AW'(addr);
        req_len    = LW'(len);
        req_cyclic = cyc;
        req_period = LW'(per);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Rejected request: one error pulse, nothing emitted (R2/R3).
    task automatic run_bad(input longint addr, input longint len,
                           input bit cyc, input longint per, input string tag);
        bit seen = 1'b0;
        offer(addr, len, cyc, per);
        chk(req_err == 1'b1, tag, "error pulse", req_err, 1);
        seg_ready = 1'b1;
        @(negedge clk);
        chk(req_err == 1'b0, tag, "error pulse width", req_err, 0);
        repeat (40) begin
            if (seg_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, tag, "no segment after reject", seen, 0);
        chk(req_ready == 1'b1, "R9", "idle after reject", req_ready, 1);
        seg_ready = 1'b0;
    endtask

    // Accepted request: compare every segment with the reference.
    task automatic run_good(input longint addr, input longint len,
                            input bit cyc, input longint per);
        int idx = 0;
        bit stalled = 1'b0;
        logic [AW-1:0] h_addr;
        logic [LW-1:0] h_len;
        logic h_eop, h_last;
        build_exp(addr, len, cyc, per);
        offer(addr, len, cyc, per);
        chk(req_err == 1'b0, "R2", "no error on good request", req_err, 0);
        chk(req_ready == 1'b0, "R9", "busy after accept", req_ready, 0);
        while (idx < e_n) begin
            if (stalled) begin
                chk(seg_valid && seg_addr == h_addr && seg_len == h_len &&
                    seg_eop == h_eop && seg_last == h_last, "R10",
                    "held segment", longint'(seg_len), longint'(h_len));
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            seg_ready = stall_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
            if (seg_valid && seg_ready) begin
                chk(seg_addr == AW'(e_addr[idx]), "R6", "segment address",
                    longint'(seg_addr), e_addr[idx]);
                chk(seg_len == LW'(e_len[idx]), e_big[idx] ? "R5" : "R4",
                    "segment length", longint'(seg_len), e_len[idx]);
                chk(seg_len != 0 && seg_len <= 16'h1FFF, "R1", "length range",
                    longint'(seg_len), 8191);
                chk(seg_eop == e_eop[idx] && seg_last == e_last[idx],
                    cyc ? "R8" : "R7", "eop/last flags",
                    longint'({seg_eop, seg_last}),
                    longint'({e_eop[idx], e_last[idx]}));
                if (idx < e_n - 1)
                    chk(!req_ready, "R9", "busy while splitting", req_ready, 0);
                idx++;
            end
            stalled = seg_valid && !seg_ready;
            h_addr = seg_addr; h_len = seg_len; h_eop = seg_eop; h_last = seg_last;
            @(negedge clk);
        end
        seg_ready = 1'b0;
        chk(!seg_valid, cyc ? "R8" : "R7", "no extra segment", seg_valid, 0);
        chk(req_ready, "R9", "idle after last", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
        chk(seg_valid == 1'b0, "R11", "reset seg_valid", seg_valid, 0);
        chk(req_err == 1'b0, "R11", "reset req_err", req_err, 0);

        // Small and boundary lengths, non-cyclic.
        for (int l = 1; l <= 12; l++) run_good(32'h1000_0000 + 4 * l, l, 0, 0);
        stall_mode = 1'b1;
        for (int l = 8185; l <= 8200; l++) run_good(32'h2000_0000, l, 0, 0);
        for (int l = 16376; l <= 16396; l += 4) run_good(32'h2100_0000, l, 0, 0);
        for (int l = 24560; l <= 24580; l += 5) run_good(32'h2200_0100, l, 0, 0);
        for (int l = 4; l <= 65535; l += 4093) run_good(32'h3000_0000 + l * 4, l, 0, 0);
        run_good(32'h3F00_0000, 65535, 0, 0);
        run_good(32'h3F00_0004, 65532, 0, 0);

        // Cyclic buffers.
        run_good(32'h4000_0000, 32768, 1, 8192);
        run_good(32'h4100_0000, 40000, 1, 10000);
        run_good(32'h4200_0000, 30000, 1, 7000);
        run_good(32'h4300_0000, 24564, 1, 8188);
        run_good(32'h4400_0000, 16384, 1, 16384);
        run_good(32'h4500_0000, 20000, 1, 3000);
        run_good(32'h4600_0000, 50000, 1, 20000);
        stall_mode = 1'b0;
        run_good(32'h4700_0000, 65535, 1, 8191);

        // Rejections.
        for (int lo = 1; lo < 4; lo++) begin
            run_bad(32'h5000_0000 + lo, 100, 0, 0, "R2");
            run_bad(32'h5000_0000 + lo, 20000, 0, 0, "R2");
            run_bad(32'h5000_0000 + lo, 20000, 1, 5000, "R2");
        end
        run_bad(32'h5100_0000, 0, 0, 0, "R3");
        run_bad(32'h5100_0000, 0, 1, 0, "R3");
        run_bad(32'h5100_0000, 1000, 1, 0, "R3");
        run_bad(32'h5100_0000, 1000, 1, 1004, "R3");
        // Still operational after rejections.
        run_good(32'h5200_0000, 9000, 0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule